// File: doc/BRIEF.md
# Radix-4 Booth Multiplier

An 8-by-8 multiplier that recodes its second operand into signed radix-4 digits. Each digit picks a partial product from the set 0, +M, -M, +2M and -2M, where M is the first operand. Because each digit covers two bits, the number of partial products is roughly half the operand width. The same datapath serves two's-complement and unsigned operands, and a mode input selects between them. The rows are aligned by weight, sign-extended to the product width and added, giving a 16-bit product.

With the output register enabled (the default), a result appears one clock after its operands are presented with a valid strobe. Without it, the block is purely combinational.

Top module: `radix4_mult`

## Requirements
- R1: The multiplier is extended and a zero bit is appended below its LSB. Three-bit windows, overlapping by one bit, are taken starting at the LSB and stepping by two bits. Window i covers bits 2i+1, 2i and 2i-1, and bit -1 is the appended zero.
- R2: A window (hi, mid, lo) selects the digit as follows: 000 gives 0, 001 gives +1, 010 gives +1, 011 gives +2, 100 gives -2, 101 gives -1, 110 gives -1 and 111 gives 0. At most one magnitude (1 or 2) is selected.
- R3: With `signed_i`=1, `product_o` is the 16-bit two's-complement product of `a_i` and `b_i`, both read as two's complement.
- R4: With `signed_i`=0, `product_o` is the 16-bit unsigned product of `a_i` and `b_i`.
- R5: A negative digit forms its row by inverting M or 2M and adding one at the row's weight. 2M is M shifted left by one bit, so a multiplier of -2 (0xFE, signed) yields -2·M.
- R6: In unsigned mode both operands are zero-extended to 10 bits, which gives five windows. A multiplier with its MSB set (0x80) is therefore read as +128.
- R7: In signed mode the operands are sign-extended, so the fifth window always decodes to digit 0. A multiplier of 0x80 is read as -128.
- R8: Reset clears `out_valid_o` and `product_o`. `out_valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was high.
- R9: While `in_valid_i` is low, `product_o` holds its last value whatever the operands do.
- R10: A zero in either operand gives a zero product in both modes.
- R11: The extreme cases are exact: 0x80·0x80 signed gives 0x4000, and 0xFF·0xFF unsigned gives 0xFE01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| a_i | input | 8 | Multiplicand |
| b_i | input | 8 | Multiplier (recoded) |
| out_valid_o | output | 1 | Product valid |
| product_o | output | 16 | Product |

## Verification
The assertions assume that `signed_i` and both operands are known (not X) whenever they are sampled. They also assume that `in_valid_i` is low while reset is asserted, so the first checked cycle after reset starts from an empty output stage. The stimulus holds `in_valid_i` low and the operands at zero through reset. It then changes the inputs only on falling edges and sweeps every operand pair in each mode, so every window pattern and both extension rules occur.

// File: rtl/radix4_mult_pkg.sv
package radix4_mult_pkg;
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import radix4_mult_pkg::*;
(
  input  logic [2:0]   trip_i,
  output booth_digit_t dig_o
);
  always_comb begin
    dig_o.one = trip_i[1] ^ trip_i[0];
    dig_o.two = (trip_i == 3'b011) || (trip_i == 3'b100);
    dig_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  end
endmodule

// File: rtl/booth_pp.sv
module booth_pp
  import radix4_mult_pkg::*;
#(
  parameter int unsigned M_W  = 10,
  parameter int unsigned PP_W = M_W + 1
) (
  input  logic [M_W-1:0]  m_i,
  input  booth_digit_t    dig_i,
  output logic [PP_W-1:0] row_o,
  output logic            neg_o
);
  logic [PP_W-1:0] mag;

  always_comb begin
    if (dig_i.two)      mag = {m_i, 1'b0};
    else if (dig_i.one) mag = {m_i[M_W-1], m_i};
    else                mag = '0;
    // ones' complement here; the +1 is added at the row weight by the summer
    row_o = mag ^ {PP_W{dig_i.neg}};
    neg_o = dig_i.neg;
  end

  always_comb begin
    assert_digit_onehot_R2: assert (!(dig_i.one && dig_i.two));
  end
endmodule

// File: rtl/radix4_mult.sv
module radix4_mult
  import radix4_mult_pkg::*;
#(
  parameter int unsigned OP_W   = 8,
  parameter bit          REG_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              signed_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              out_valid_o,
  output logic [2*OP_W-1:0] product_o
);
  localparam int unsigned EXT_W  = OP_W + 2 - (OP_W % 2);
  localparam int unsigned N_PP   = EXT_W / 2;
  localparam int unsigned PP_W   = EXT_W + 1;
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [EXT_W-1:0] a_ext, b_ext;
  logic [EXT_W:0]   b_win;
  logic             a_fill, b_fill;

  always_comb begin
    a_fill = signed_i & a_i[OP_W-1];
    b_fill = signed_i & b_i[OP_W-1];
    a_ext  = {{(EXT_W-OP_W){a_fill}}, a_i};
    b_ext  = {{(EXT_W-OP_W){b_fill}}, b_i};
    b_win  = {b_ext, 1'b0};
  end

  booth_digit_t            dig  [N_PP];
  logic [PP_W-1:0]         row  [N_PP];
  logic [N_PP-1:0]         neg;
  logic [PROD_W-1:0]       term [N_PP];

  for (genvar i = 0; i < N_PP; i++) begin : g_pp
    booth_enc u_enc (
      .trip_i (b_win[2*i +: 3]),
      .dig_o  (dig[i])
    );
    booth_pp #(.M_W(EXT_W), .PP_W(PP_W)) u_pp (
      .m_i   (a_ext),
      .dig_i (dig[i]),
      .row_o (row[i]),
      .neg_o (neg[i])
    );
    if (PROD_W > PP_W) begin : g_sx
      assign term[i] = {{(PROD_W-PP_W){row[i][PP_W-1]}}, row[i]};
    end else begin : g_tr
      assign term[i] = row[i][PROD_W-1:0];
    end
  end

  logic [PROD_W-1:0] prod_c;
  always_comb begin
    prod_c = '0;
    for (int i = 0; i < N_PP; i++) begin
      prod_c = prod_c + (term[i] << (2*i)) + (PROD_W'(neg[i]) << (2*i));
    end
  end

  always_comb begin
    if (signed_i) begin
      assert_top_digit_zero_R7: assert (!dig[N_PP-1].one && !dig[N_PP-1].two);
    end
  end

  if (REG_EN) begin : g_reg
    logic              vld_q;
    logic [PROD_W-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else begin
        vld_q <= in_valid_i;
        if (in_valid_i) prod_q <= prod_c;
      end
    end
    assign out_valid_o = vld_q;
    assign product_o   = prod_q;

    assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);
    assert_valid_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);
    assert_product_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(product_o));
    assert_zero_operand_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && (a_i == '0 || b_i == '0)) |=> (product_o == '0));
  end else begin : g_comb
    assign out_valid_o = in_valid_i;
    assign product_o   = prod_c;
  end
endmodule

// File: tb/sim_radix4_mult.sv
module sim_radix4_mult;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic        out_valid_o;
  logic [15:0] product_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  radix4_mult u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .product_o(product_o)
  );

  function automatic logic [15:0] ref_mul(input logic s, input logic [7:0] a, input logic [7:0] b);
    int x;
    if (s) x = int'($signed(a)) * int'($signed(b));
    else   x = int'(a) * int'(b);
    return x[15:0];
  endfunction

  task automatic compare(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk_i);
    signed_i = s; a_i = a; b_i = b; in_valid_i = 1'b1;
    exp_q.push_back(ref_mul(s, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8: actual out_valid 1 expected 0 (no pending item)");
      end else begin
        compare(product_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk_i);
    compare({15'd0, out_valid_o}, 16'd0, "R8 reset valid");
    compare(product_o, 16'd0, "R8 reset product");
    rst_ni = 1'b1;

    apply(1'b0, 8'd5, 8'h01, "R2 digit +1");
    apply(1'b0, 8'd3, 8'h02, "R1 windows -2,+1");
    apply(1'b1, 8'd7, 8'hFE, "R5 negative 2M");
    apply(1'b1, 8'hF9, 8'h03, "R5 negative M");
    apply(1'b0, 8'd3, 8'h80, "R6 unsigned msb");
    apply(1'b1, 8'd3, 8'h80, "R7 signed msb");
    apply(1'b0, 8'd0, 8'hAB, "R10 zero a");
    apply(1'b1, 8'h9C, 8'd0, "R10 zero b");
    apply(1'b1, 8'h80, 8'h80, "R11 signed extreme");
    apply(1'b0, 8'hFF, 8'hFF, "R11 unsigned extreme");
    held = ref_mul(1'b0, 8'hFF, 8'hFF);

    // R8: valid high one cycle after, low after a gap
    idle();
    compare({15'd0, out_valid_o}, 16'd1, "R8 valid after strobe");
    @(negedge clk_i);
    compare({15'd0, out_valid_o}, 16'd0, "R8 valid after gap");

    // R9: operands move while in_valid low
    a_i = 8'h12; b_i = 8'h34; signed_i = 1'b1;
    @(negedge clk_i);
    a_i = 8'h77; b_i = 8'hC1;
    @(negedge clk_i);
    compare(product_o, held, "R9 hold");

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          apply(s[0], a[7:0], b[7:0], s ? "R3 signed sweep" : "R4 unsigned sweep");
        end
      end
    end
    idle();
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8: actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule